// File: doc/BRIEF.md
# Host Transaction Request Queue Manager

This block is the front end where a full-speed USB host controller takes in transaction requests. Software describes each host channel over a register bus. It gives the channel its endpoint class (periodic or nonperiodic), its token direction and its transfer size in bytes. Software then enables the channel and, for OUT transfers, writes the payload one 32-bit word at a time through that channel's push command. The block keeps two separate paths, one periodic and one nonperiodic. Each path has a transmit data FIFO and a request queue. A channel's endpoint class decides which path its words and its request entry go to.

An IN request, or an OUT request with a zero-byte size, is queued as soon as the channel is enabled. An OUT request with a payload is queued only in the cycle its final payload word is written into the FIFO. A downstream executor drains the request queues through a valid/ready port and serves the periodic queue first. It takes payload words from one valid/ready data port per FIFO. Software can read how much room is left in each queue and each FIFO. A per-FIFO interrupt level can signal half-empty or empty. Any command the block cannot fully honour is dropped whole and sets a sticky error flag.

Top module: `hrq_req_manager`

## Requirements
- R1: A push command (cmd_op = 2'b11) to an armed OUT channel writes cmd_data into the periodic transmit FIFO when the channel's stored class bit is 1, and into the nonperiodic FIFO when it is 0. The other FIFO is left untouched.
- R2: A config command (cmd_op = 2'b01) stores the class, the direction (cmd_dir_in = 1 means IN) and a payload length of ceil(cmd_bytes/4) words. For an OUT channel armed by enable, no queue entry exists until the push that writes the final word. That push appends one entry {channel, direction = OUT, word count} to its class's queue and disarms the channel.
- R3: An enable command (cmd_op = 2'b10) to an unarmed channel that is configured IN, or configured with zero bytes, appends an entry to its class's queue in the same cycle and does not arm the channel. Pushes to such a channel are refused.
- R4: pq_free and npq_free equal Q_DEPTH minus the entries held in the periodic and nonperiodic request queues, one cycle after each append or pop.
- R5: pfifo_free and npfifo_free equal FIFO_DEPTH minus the words held in the periodic and nonperiodic FIFOs.
- R6: With irq_on_empty = 0, each FIFO interrupt is high while the FIFO holds at most FIFO_DEPTH/2 words. With irq_on_empty = 1, it is high only while the FIFO is empty.
- R7: req_valid is high while either queue holds an entry. The presented entry is the oldest periodic entry if there is one, otherwise the oldest nonperiodic entry. It is removed only on a cycle with req_ready high.
- R8: The following commands are refused with no change to any queue, FIFO or channel state, and they set err_flag, which stays high until reset: a push to an unarmed channel; a push into a full FIFO; a final-word push whose queue is full; an enable whose immediate entry finds the queue full; an enable or config to an armed channel.
- R9: After reset, both queues and both FIFOs are empty, all channels are unarmed, req_valid, pdat_valid, npdat_valid and err_flag are low, and both interrupts are high in half-empty mode.
- R10: Each data port presents its FIFO's oldest word while the FIFO is non-empty and advances on a cycle with its ready high, so the words come out in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command: 00 idle, 01 config, 10 enable, 11 push |
| cmd_ch | input | $clog2(NUM_CH) | Target host channel |
| cmd_periodic | input | 1 | Config: 1 periodic class, 0 nonperiodic |
| cmd_dir_in | input | 1 | Config: 1 IN token, 0 OUT token |
| cmd_bytes | input | XFER_W | Config: transfer size in bytes |
| cmd_data | input | DATA_W | Push: payload word |
| irq_on_empty | input | 1 | Interrupt condition: 0 half empty, 1 empty |
| req_valid | output | 1 | A queued request is presented |
| req_ready | input | 1 | Executor takes the presented request |
| req_periodic | output | 1 | Presented request came from the periodic queue |
| req_ch | output | $clog2(NUM_CH) | Channel of the presented request |
| req_dir_in | output | 1 | Direction of the presented request |
| req_words | output | XFER_W-1 | Payload word count of the presented request |
| pdat_valid | output | 1 | Periodic FIFO holds a word |
| pdat_ready | input | 1 | Executor takes a periodic word |
| pdat_data | output | DATA_W | Oldest periodic word |
| npdat_valid | output | 1 | Nonperiodic FIFO holds a word |
| npdat_ready | input | 1 | Executor takes a nonperiodic word |
| npdat_data | output | DATA_W | Oldest nonperiodic word |
| pq_free | output | $clog2(Q_DEPTH+1) | Free periodic queue entries |
| npq_free | output | $clog2(Q_DEPTH+1) | Free nonperiodic queue entries |
| pfifo_free | output | $clog2(FIFO_DEPTH+1) | Free periodic FIFO words |
| npfifo_free | output | $clog2(FIFO_DEPTH+1) | Free nonperiodic FIFO words |
| p_irq | output | 1 | Periodic FIFO interrupt level |
| np_irq | output | 1 | Nonperiodic FIFO interrupt level |
| err_flag | output | 1 | Sticky refusal flag |

## Verification
The hardest case to reach is a final payload word that lands while its request queue is full. Getting there takes a full queue on the same class, built from immediate IN entries, and also an OUT channel that is part way through its payload. The bench fills the nonperiodic queue with eight IN enables, arms a two-word OUT channel, and pushes its first word. The second push must then be refused whole. After one entry is drained, the retried push must complete the request. A long stretch of random commands and random ready levels follows. In that stretch, configs and enables to armed channels, full-FIFO pushes and priority switches under backpressure all occur, and each is compared cycle by cycle against a behavioural model.

// File: rtl/hrq_pkg.sv
package hrq_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'b00,
    OP_CONFIG = 2'b01,
    OP_ENABLE = 2'b10,
    OP_PUSH   = 2'b11
  } hrq_op_e;

  // path index of the two FIFO/queue pairs
  localparam int PATH_NP = 0;
  localparam int PATH_P  = 1;

  // payload length in whole 32-bit words
  function automatic int unsigned words_for(input int unsigned nbytes);
    return (nbytes + 3) >> 2;
  endfunction

  // interrupt condition on a FIFO occupancy
  function automatic logic fifo_irq(input int unsigned used, input int unsigned depth,
                                    input logic on_empty);
    if (on_empty) return used == 0;
    return used <= depth / 2;
  endfunction

endpackage

// File: rtl/hrq_fifo.sv
module hrq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_acc, rd_acc;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign wr_acc  = wr_en && !full;
  assign rd_acc  = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_acc) wr_ptr <= step(wr_ptr);
      if (rd_acc) rd_ptr <= step(rd_ptr);
      count <= count + CW'(wr_acc) - CW'(rd_acc);
    end
  end
endmodule

// File: rtl/hrq_chan_table.sv
module hrq_chan_table #(
  parameter int NUM_CH = 4,
  parameter int XFER_W = 7
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [$clog2(NUM_CH)-1:0]          sel_ch,
  input  logic                               cfg_wr,
  input  logic                               cfg_periodic,
  input  logic                               cfg_dir_in,
  input  logic [XFER_W-1:0]                  cfg_bytes,
  input  logic                               arm,
  input  logic                               push_acc,
  input  logic                               done,
  output logic [NUM_CH-1:0]                  periodic_o,
  output logic [NUM_CH-1:0]                  dir_in_o,
  output logic [NUM_CH-1:0]                  armed_o,
  output logic [NUM_CH-1:0][XFER_W-2:0]      words_o,
  output logic [NUM_CH-1:0][XFER_W-2:0]      cnt_o
);
  import hrq_pkg::*;
  localparam int WW = XFER_W - 1;

  logic [WW-1:0] cfg_words;
  assign cfg_words = WW'(words_for(int'(cfg_bytes)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = (sel_ch == ($clog2(NUM_CH))'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        periodic_o[c] <= 1'b0;
        dir_in_o[c]   <= 1'b0;
        armed_o[c]    <= 1'b0;
        words_o[c]    <= '0;
        cnt_o[c]      <= '0;
      end else if (hit) begin
        if (cfg_wr) begin
          periodic_o[c] <= cfg_periodic;
          dir_in_o[c]   <= cfg_dir_in;
          words_o[c]    <= cfg_words;
          cnt_o[c]      <= '0;
        end
        if (arm) begin
          armed_o[c] <= 1'b1;
          cnt_o[c]   <= '0;
        end
        if (done) begin
          armed_o[c] <= 1'b0;
          cnt_o[c]   <= '0;
        end else if (push_acc) begin
          cnt_o[c] <= cnt_o[c] + WW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hrq_req_manager.sv
module hrq_req_manager
  import hrq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int XFER_W     = 7,
  parameter int Q_DEPTH    = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [1:0]                        cmd_op,
  input  logic [$clog2(NUM_CH)-1:0]         cmd_ch,
  input  logic                              cmd_periodic,
  input  logic                              cmd_dir_in,
  input  logic [XFER_W-1:0]                 cmd_bytes,
  input  logic [DATA_W-1:0]                 cmd_data,
  input  logic                              irq_on_empty,
  output logic                              req_valid,
  input  logic                              req_ready,
  output logic                              req_periodic,
  output logic [$clog2(NUM_CH)-1:0]         req_ch,
  output logic                              req_dir_in,
  output logic [XFER_W-2:0]                 req_words,
  output logic                              pdat_valid,
  input  logic                              pdat_ready,
  output logic [DATA_W-1:0]                 pdat_data,
  output logic                              npdat_valid,
  input  logic                              npdat_ready,
  output logic [DATA_W-1:0]                 npdat_data,
  output logic [$clog2(Q_DEPTH+1)-1:0]      pq_free,
  output logic [$clog2(Q_DEPTH+1)-1:0]      npq_free,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   pfifo_free,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   npfifo_free,
  output logic                              p_irq,
  output logic                              np_irq,
  output logic                              err_flag
);
  localparam int CHW   = $clog2(NUM_CH);
  localparam int WW    = XFER_W - 1;
  localparam int ENT_W = CHW + 1 + WW;
  localparam int QCW   = $clog2(Q_DEPTH + 1);
  localparam int FCW   = $clog2(FIFO_DEPTH + 1);

  hrq_op_e op;
  assign op = hrq_op_e'(cmd_op);

  // channel table
  logic [NUM_CH-1:0]         ch_periodic, ch_dir_in, ch_armed;
  logic [NUM_CH-1:0][WW-1:0] ch_words, ch_cnt;
  logic cfg_wr, arm, push_acc, done;

  hrq_chan_table #(.NUM_CH(NUM_CH), .XFER_W(XFER_W)) u_chan (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_ch      (cmd_ch),
    .cfg_wr      (cfg_wr),
    .cfg_periodic(cmd_periodic),
    .cfg_dir_in  (cmd_dir_in),
    .cfg_bytes   (cmd_bytes),
    .arm         (arm),
    .push_acc    (push_acc),
    .done        (done),
    .periodic_o  (ch_periodic),
    .dir_in_o    (ch_dir_in),
    .armed_o     (ch_armed),
    .words_o     (ch_words),
    .cnt_o       (ch_cnt)
  );

  logic          sel_path, sel_dir_in, sel_armed, sel_last;
  logic [WW-1:0] sel_words;
  assign sel_path   = ch_periodic[cmd_ch];
  assign sel_dir_in = ch_dir_in[cmd_ch];
  assign sel_armed  = ch_armed[cmd_ch];
  assign sel_words  = ch_words[cmd_ch];
  assign sel_last   = (ch_cnt[cmd_ch] + WW'(1)) == sel_words;

  // paths: index PATH_NP / PATH_P
  logic [1:0]             q_wr, q_rd, q_full, q_empty;
  logic [1:0]             f_wr, f_rd, f_full, f_empty;
  logic [ENT_W-1:0]       q_rdata [2];
  logic [QCW-1:0]         q_cnt   [2];
  logic [DATA_W-1:0]      f_rdata [2];
  logic [FCW-1:0]         f_cnt   [2];
  logic [1:0]             f_irq;
  logic [ENT_W-1:0]       q_wdata;

  assign q_wdata = {cmd_ch, sel_dir_in, sel_words};

  // named internal events
  logic ev_refuse, ev_last_word;
  logic [1:0] ev_q_wr;

  always_comb begin
    cfg_wr    = 1'b0;
    arm       = 1'b0;
    push_acc  = 1'b0;
    done      = 1'b0;
    q_wr      = '0;
    f_wr      = '0;
    ev_refuse = 1'b0;
    unique case (op)
      OP_CONFIG: begin
        if (sel_armed) ev_refuse = 1'b1;
        else           cfg_wr    = 1'b1;
      end
      OP_ENABLE: begin
        if (sel_armed) ev_refuse = 1'b1;
        else if (sel_dir_in || sel_words == '0) begin
          if (q_full[sel_path]) ev_refuse = 1'b1;
          else                  q_wr[sel_path] = 1'b1;
        end else arm = 1'b1;
      end
      OP_PUSH: begin
        if (!sel_armed || f_full[sel_path])  ev_refuse = 1'b1;
        else if (sel_last && q_full[sel_path]) ev_refuse = 1'b1;
        else begin
          push_acc       = 1'b1;
          f_wr[sel_path] = 1'b1;
          if (sel_last) begin
            done           = 1'b1;
            q_wr[sel_path] = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign ev_last_word = done;
  assign ev_q_wr      = q_wr;

  // executor side: periodic queue first
  assign q_rd[PATH_P]  = req_ready && !q_empty[PATH_P];
  assign q_rd[PATH_NP] = req_ready && q_empty[PATH_P] && !q_empty[PATH_NP];
  assign f_rd[PATH_P]  = pdat_ready;
  assign f_rd[PATH_NP] = npdat_ready;

  for (genvar p = 0; p < 2; p++) begin : g_path
    hrq_fifo #(.W(ENT_W), .DEPTH(Q_DEPTH)) u_req_q (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (q_wr[p]),
      .wr_data(q_wdata),
      .rd_en  (q_rd[p]),
      .rd_data(q_rdata[p]),
      .count  (q_cnt[p]),
      .full   (q_full[p]),
      .empty  (q_empty[p])
    );
    hrq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (f_wr[p]),
      .wr_data(cmd_data),
      .rd_en  (f_rd[p]),
      .rd_data(f_rdata[p]),
      .count  (f_cnt[p]),
      .full   (f_full[p]),
      .empty  (f_empty[p])
    );
    assign f_irq[p] = fifo_irq(int'(f_cnt[p]), FIFO_DEPTH, irq_on_empty);
  end

  logic             pick;
  logic [ENT_W-1:0] head;
  assign pick         = !q_empty[PATH_P];
  assign head         = q_rdata[pick];
  assign req_valid    = !q_empty[PATH_P] || !q_empty[PATH_NP];
  assign req_periodic = pick;
  assign req_ch       = head[ENT_W-1 -: CHW];
  assign req_dir_in   = head[WW];
  assign req_words    = head[WW-1:0];

  assign pdat_valid  = !f_empty[PATH_P];
  assign pdat_data   = f_rdata[PATH_P];
  assign npdat_valid = !f_empty[PATH_NP];
  assign npdat_data  = f_rdata[PATH_NP];

  assign pq_free     = QCW'(Q_DEPTH) - q_cnt[PATH_P];
  assign npq_free    = QCW'(Q_DEPTH) - q_cnt[PATH_NP];
  assign pfifo_free  = FCW'(FIFO_DEPTH) - f_cnt[PATH_P];
  assign npfifo_free = FCW'(FIFO_DEPTH) - f_cnt[PATH_NP];
  assign p_irq       = f_irq[PATH_P];
  assign np_irq      = f_irq[PATH_NP];

  always_ff @(posedge clk) begin
    if (!rst_n)         err_flag <= 1'b0;
    else if (ev_refuse) err_flag <= 1'b1;
  end
endmodule

// File: rtl/hrq_checker.sv
module hrq_checker #(
  parameter int Q_DEPTH    = 8,
  parameter int FIFO_DEPTH = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic                            req_ready,
  input logic                            req_periodic,
  input logic [$clog2(Q_DEPTH+1)-1:0]    pq_free,
  input logic [$clog2(Q_DEPTH+1)-1:0]    npq_free,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] pfifo_free,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] npfifo_free,
  input logic                            p_irq,
  input logic                            np_irq,
  input logic                            irq_on_empty,
  input logic                            err_flag,
  input logic                            ev_refuse,
  input logic                            ev_last_word,
  input logic [1:0]                      ev_q_wr
);
  AST_PERIODIC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pq_free) != Q_DEPTH) |-> (req_valid && req_periodic)); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid); // R7

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pq_free) <= Q_DEPTH) && (int'(npq_free) <= Q_DEPTH)); // R4

  AST_PQ_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q_wr[1] && !(req_valid && req_ready && req_periodic)) |=>
      (int'(pq_free) + 1 == int'($past(pq_free)))); // R4

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pfifo_free) <= FIFO_DEPTH) && (int'(npfifo_free) <= FIFO_DEPTH)); // R5

  AST_EMPTY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_on_empty && (p_irq || np_irq)) |->
      ((!p_irq || int'(pfifo_free) == FIFO_DEPTH) &&
       (!np_irq || int'(npfifo_free) == FIFO_DEPTH))); // R6

  AST_LAST_WORD_QUEUES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_word |-> (ev_q_wr != 2'b00)); // R2

  AST_REFUSE_NO_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse |-> (ev_q_wr == 2'b00)); // R8

  AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse |=> err_flag); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R8
endmodule

bind hrq_req_manager hrq_checker #(.Q_DEPTH(Q_DEPTH), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_periodic(req_periodic),
  .pq_free     (pq_free),
  .npq_free    (npq_free),
  .pfifo_free  (pfifo_free),
  .npfifo_free (npfifo_free),
  .p_irq       (p_irq),
  .np_irq      (np_irq),
  .irq_on_empty(irq_on_empty),
  .err_flag    (err_flag),
  .ev_refuse   (ev_refuse),
  .ev_last_word(ev_last_word),
  .ev_q_wr     (ev_q_wr)
);

// File: tb/hrq_req_manager_test.sv
`timescale 1ns/100ps
module hrq_req_manager_test;
  localparam int NCH = 4;
  localparam int XW  = 7;
  localparam int QD  = 8;
  localparam int FD  = 16;

  localparam logic [1:0] C_IDLE = 2'b00, C_CFG = 2'b01, C_EN = 2'b10, C_PUSH = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmd_op = C_IDLE;
  logic [1:0] cmd_ch = '0;
  logic cmd_periodic = 1'b0, cmd_dir_in = 1'b0;
  logic [XW-1:0] cmd_bytes = '0;
  logic [31:0] cmd_data = '0;
  logic irq_on_empty = 1'b0;
  logic req_ready = 1'b0, pdat_ready = 1'b0, npdat_ready = 1'b0;
  logic req_valid, req_periodic, req_dir_in;
  logic [1:0] req_ch;
  logic [XW-2:0] req_words;
  logic pdat_valid, npdat_valid;
  logic [31:0] pdat_data, npdat_data;
  logic [3:0] pq_free, npq_free;
  logic [4:0] pfifo_free, npfifo_free;
  logic p_irq, np_irq, err_flag;

  always #2.5 clk = ~clk;

  hrq_req_manager #(.NUM_CH(NCH), .XFER_W(XW), .Q_DEPTH(QD), .FIFO_DEPTH(FD), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_ch(cmd_ch), .cmd_periodic(cmd_periodic),
    .cmd_dir_in(cmd_dir_in), .cmd_bytes(cmd_bytes), .cmd_data(cmd_data),
    .irq_on_empty(irq_on_empty), .req_valid(req_valid), .req_ready(req_ready),
    .req_periodic(req_periodic), .req_ch(req_ch), .req_dir_in(req_dir_in),
    .req_words(req_words), .pdat_valid(pdat_valid), .pdat_ready(pdat_ready),
    .pdat_data(pdat_data), .npdat_valid(npdat_valid), .npdat_ready(npdat_ready),
    .npdat_data(npdat_data), .pq_free(pq_free), .npq_free(npq_free),
    .pfifo_free(pfifo_free), .npfifo_free(npfifo_free), .p_irq(p_irq),
    .np_irq(np_irq), .err_flag(err_flag)
  );

  int n_checks = 0;
  int n_errs   = 0;

  task automatic chk(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { int ch; int dir; int words; } ent_t;
  ent_t mq_p[$], mq_np[$];
  int   mf_p[$], mf_np[$];
  int   m_per[NCH], m_dir[NCH], m_words[NCH], m_armed[NCH], m_cnt[NCH];
  int   m_err;

  function automatic int qsize(input int per);
    return per ? mq_p.size() : mq_np.size();
  endfunction
  function automatic int fsize(input int per);
    return per ? mf_p.size() : mf_np.size();
  endfunction

  always @(posedge clk) begin
    int sp, snp, sfp, sfnp, c, per, last;
    ent_t e;
    if (!rst_n) begin
      mq_p.delete(); mq_np.delete(); mf_p.delete(); mf_np.delete();
      for (int i = 0; i < NCH; i++) begin
        m_per[i] = 0; m_dir[i] = 0; m_words[i] = 0; m_armed[i] = 0; m_cnt[i] = 0;
      end
      m_err = 0;
    end else begin
      sp = mq_p.size(); snp = mq_np.size(); sfp = mf_p.size(); sfnp = mf_np.size();
      c = int'(cmd_ch); per = m_per[c];
      e.ch = c; e.dir = m_dir[c]; e.words = m_words[c];
      case (cmd_op)
        C_CFG: if (m_armed[c] != 0) m_err = 1;
               else begin
                 m_per[c] = int'(cmd_periodic); m_dir[c] = int'(cmd_dir_in);
                 m_words[c] = (int'(cmd_bytes) + 3) / 4; m_cnt[c] = 0;
               end
        C_EN: if (m_armed[c] != 0) m_err = 1;
              else if (m_dir[c] != 0 || m_words[c] == 0) begin
                if (qsize(per) == QD) m_err = 1;
                else if (per != 0) mq_p.push_back(e); else mq_np.push_back(e);
              end else begin m_armed[c] = 1; m_cnt[c] = 0; end
        C_PUSH: begin
          last = (m_cnt[c] + 1 == m_words[c]);
          if (m_armed[c] == 0 || fsize(per) == FD) m_err = 1;
          else if (last != 0 && qsize(per) == QD) m_err = 1;
          else begin
            if (per != 0) mf_p.push_back(int'(cmd_data)); else mf_np.push_back(int'(cmd_data));
            m_cnt[c]++;
            if (last != 0) begin
              if (per != 0) mq_p.push_back(e); else mq_np.push_back(e);
              m_armed[c] = 0; m_cnt[c] = 0;
            end
          end
        end
        default: ;
      endcase
      if (req_ready && sp > 0) void'(mq_p.pop_front());
      else if (req_ready && snp > 0) void'(mq_np.pop_front());
      if (pdat_ready && sfp > 0) void'(mf_p.pop_front());
      if (npdat_ready && sfnp > 0) void'(mf_np.pop_front());
    end
  end

  function automatic int irq_exp(input int used);
    return irq_on_empty ? int'(used == 0) : int'(used <= FD / 2);
  endfunction

  bit cmp_on = 0;
  always @(posedge clk) begin
    #1;
    if (rst_n && cmp_on) begin
      ent_t h;
      chk(int'(pq_free), QD - mq_p.size(), "R4 periodic queue free");
      chk(int'(npq_free), QD - mq_np.size(), "R4 nonperiodic queue free");
      chk(int'(pfifo_free), FD - mf_p.size(), "R5 periodic fifo free");
      chk(int'(npfifo_free), FD - mf_np.size(), "R5 nonperiodic fifo free");
      chk(int'(p_irq), irq_exp(mf_p.size()), "R6 periodic irq");
      chk(int'(np_irq), irq_exp(mf_np.size()), "R6 nonperiodic irq");
      chk(int'(err_flag), m_err, "R8 sticky error");
      chk(int'(req_valid), int'(mq_p.size() + mq_np.size() > 0), "R7 req_valid");
      if (mq_p.size() + mq_np.size() > 0) begin
        h = (mq_p.size() > 0) ? mq_p[0] : mq_np[0];
        chk(int'(req_periodic), int'(mq_p.size() > 0), "R7 priority");
        chk(int'(req_ch), h.ch, "R7 head channel");
        chk(int'(req_dir_in), h.dir, "R7 head direction");
        chk(int'(req_words), h.words, "R2 head word count");
      end
      chk(int'(pdat_valid), int'(mf_p.size() > 0), "R10 pdat_valid");
      if (mf_p.size() > 0) chk(int'(pdat_data), mf_p[0], "R1 periodic data");
      chk(int'(npdat_valid), int'(mf_np.size() > 0), "R10 npdat_valid");
      if (mf_np.size() > 0) chk(int'(npdat_data), mf_np[0], "R1 nonperiodic data");
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input logic [1:0] o, input int ch, input bit per, input bit din,
                    input int nbytes, input int data);
    cmd_op = o; cmd_ch = 2'(ch); cmd_periodic = per; cmd_dir_in = din;
    cmd_bytes = XW'(nbytes); cmd_data = 32'(data);
    @(negedge clk);
    cmd_op = C_IDLE;
  endtask

  task automatic drain(input int n);
    req_ready = 1; pdat_ready = 1; npdat_ready = 1;
    repeat (n) @(negedge clk);
    req_ready = 0; pdat_ready = 0; npdat_ready = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_errs++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // R9 reset state
    chk(int'(pq_free), QD, "R9 pq_free"); chk(int'(npq_free), QD, "R9 npq_free");
    chk(int'(pfifo_free), FD, "R9 pfifo_free"); chk(int'(npfifo_free), FD, "R9 npfifo_free");
    chk(int'(req_valid), 0, "R9 req_valid"); chk(int'(err_flag), 0, "R9 err_flag");
    chk(int'(p_irq), 1, "R9 p_irq"); chk(int'(pdat_valid), 0, "R9 pdat_valid");

    // R2 OUT request appears only with last word; R1 routing to nonperiodic
    op(C_CFG, 0, 0, 0, 10, 0);
    op(C_EN, 0, 0, 0, 0, 0);
    op(C_PUSH, 0, 0, 0, 0, 'hA1);
    op(C_PUSH, 0, 0, 0, 0, 'hA2);
    chk(int'(npq_free), QD, "R2 no entry before last word");
    chk(int'(npfifo_free), FD - 2, "R1 words in nonperiodic fifo");
    op(C_PUSH, 0, 0, 0, 0, 'hA3);
    chk(int'(npq_free), QD - 1, "R2 entry on last word");
    chk(int'(req_words), 3, "R2 ceil(10/4) words");
    chk(int'(pfifo_free), FD, "R1 periodic fifo untouched");

    // R3 IN enable queues at once; R7 periodic served first
    op(C_CFG, 1, 1, 1, 64, 0);
    op(C_EN, 1, 0, 0, 0, 0);
    chk(int'(pq_free), QD - 1, "R3 IN enable appends");
    chk(int'(req_periodic), 1, "R7 periodic first");
    chk(int'(req_ch), 1, "R7 periodic head channel");

    // R1 periodic routing
    op(C_CFG, 2, 1, 0, 4, 0);
    op(C_EN, 2, 0, 0, 0, 0);
    op(C_PUSH, 2, 0, 0, 0, 'hB1);
    chk(int'(pfifo_free), FD - 1, "R1 periodic fifo word");
    chk(int'(pdat_data), 'hB1, "R10 periodic data head");
    chk(int'(pq_free), QD - 2, "R2 one-word OUT entry");

    // R8 push to unarmed channel
    chk(int'(err_flag), 0, "R8 no error yet");
    op(C_PUSH, 3, 0, 0, 0, 'hDEAD);
    chk(int'(err_flag), 1, "R8 unarmed push flags");
    chk(int'(npfifo_free), FD - 3, "R8 unarmed push dropped");

    // R8 full periodic queue refuses IN enable
    for (int i = 0; i < 6; i++) op(C_EN, 1, 0, 0, 0, 0);
    chk(int'(pq_free), 0, "R4 periodic queue full");
    op(C_EN, 1, 0, 0, 0, 0);
    chk(int'(pq_free), 0, "R8 full queue enable refused");

    // R6 interrupt modes
    chk(int'(p_irq), 1, "R6 half-empty mode");
    irq_on_empty = 1; #1;
    chk(int'(p_irq), 0, "R6 empty mode, 1 word held");
    @(negedge clk);
    drain(12);
    chk(int'(pq_free), QD, "R7 periodic drained");
    chk(int'(npq_free), QD, "R7 nonperiodic drained");
    chk(int'(p_irq), 1, "R6 empty mode, fifo empty");
    irq_on_empty = 0;

    // R8 last word with full queue is refused whole, then retried
    op(C_CFG, 0, 0, 1, 0, 0);
    for (int i = 0; i < 8; i++) op(C_EN, 0, 0, 0, 0, 0);
    chk(int'(npq_free), 0, "R4 nonperiodic queue full");
    op(C_CFG, 3, 0, 0, 8, 0);
    op(C_EN, 3, 0, 0, 0, 0);
    op(C_PUSH, 3, 0, 0, 0, 'hC1);
    chk(int'(npfifo_free), FD - 1, "R1 first word accepted");
    op(C_PUSH, 3, 0, 0, 0, 'hC2);
    chk(int'(npfifo_free), FD - 1, "R8 last word refused, no data");
    chk(int'(npq_free), 0, "R8 last word refused, no entry");
    req_ready = 1; @(negedge clk); req_ready = 0;
    op(C_PUSH, 3, 0, 0, 0, 'hC2);
    chk(int'(npfifo_free), FD - 2, "R2 retried last word stored");
    chk(int'(npq_free), 0, "R2 retried last word queued");

    // R8 enable/config to armed channel refused
    op(C_CFG, 2, 1, 0, 8, 0);
    op(C_EN, 2, 0, 0, 0, 0);
    op(C_EN, 2, 0, 0, 0, 0);
    op(C_CFG, 2, 0, 1, 4, 0);
    op(C_PUSH, 2, 0, 0, 0, 'hD1);
    chk(int'(pfifo_free), FD - 1, "R8 armed channel kept its config");
    op(C_PUSH, 2, 0, 0, 0, 'hD2);
    chk(int'(pq_free), QD - 1, "R2 two-word entry");

    // R3 zero-length OUT queues on enable and is not armed
    op(C_CFG, 1, 1, 0, 0, 0);
    op(C_EN, 1, 0, 0, 0, 0);
    chk(int'(pq_free), QD - 2, "R3 zero-length enable appends");
    op(C_PUSH, 1, 0, 0, 0, 'hE1);
    chk(int'(pfifo_free), FD - 2, "R3 zero-length push refused");

    // R8 full FIFO
    drain(20);
    op(C_CFG, 3, 0, 0, 127, 0);
    op(C_EN, 3, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) op(C_PUSH, 3, 0, 0, 0, 'h100 + i);
    chk(int'(npfifo_free), 0, "R5 nonperiodic fifo full");
    op(C_PUSH, 3, 0, 0, 0, 'h1FF);
    chk(int'(npfifo_free), 0, "R8 full fifo push refused");
    chk(int'(npdat_data), 'h100, "R10 oldest word first");
    npdat_ready = 1; repeat (16) @(negedge clk); npdat_ready = 0;
    for (int i = 16; i < 32; i++) op(C_PUSH, 3, 0, 0, 0, 'h100 + i);
    chk(int'(req_words), 32, "R2 32-word entry");
    chk(int'(req_periodic), 0, "R7 nonperiodic served when periodic empty");

    // random phase compared against the model each cycle
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      req_ready   = 1'($urandom_range(0, 3) == 0);
      pdat_ready  = 1'($urandom_range(0, 2) == 0);
      npdat_ready = 1'($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 49) == 0) irq_on_empty = ~irq_on_empty;
      cmd_ch       = 2'($urandom_range(0, 3));
      cmd_periodic = 1'($urandom_range(0, 1));
      cmd_dir_in   = 1'($urandom_range(0, 3) == 0);
      cmd_bytes    = XW'($urandom_range(0, 24));
      cmd_data     = $urandom;
      cmd_op = (r < 2) ? C_CFG : (r < 4) ? C_EN : (r < 8) ? C_PUSH : C_IDLE;
      @(negedge clk);
    end
    cmd_op = C_IDLE;
    drain(40);
    chk(int'(req_valid), 0, "R7 all requests drained");
    chk(int'(npdat_valid), 0, "R10 all words drained");

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule